// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This unit examines one selected bit of an operand, reports through a zero flag whether that bit was clear, and in the same operation may force the bit high, force it low or invert it. It sits in the execute stage of a processor datapath: operand fetch and address generation happen upstream, and the modified operand and updated flags are handed to writeback one clock after the request.

The operand is either a full 32-bit register or an 8-bit memory byte that arrives in the low byte of the operand bus. The bit number is reduced modulo the width of the chosen operand kind, so any bit number is accepted. The zero flag is always derived from the selected bit as it stood before modification. All other flag bits pass through untouched, and a write-enable output tells writeback whether the operand must be stored.

Top module: `bit_tam_unit`

## Requirements
- R1: While reset is asserted, and until the first request after its release, out_valid and wr_en are 0.
- R2: Results appear exactly one clock after a request: out_valid in a cycle equals in_valid of the previous cycle.
- R3: For every operation, flags_out bit 2 (the zero flag) is 1 when the selected bit of the operand was 0 before modification, and 0 otherwise.
- R4: Operation code 2'b00 (test) returns the operand unchanged and leaves wr_en at 0.
- R5: Operation code 2'b01 (set) returns the operand with the selected bit forced to 1.
- R6: Operation code 2'b10 (clear) returns the operand with the selected bit forced to 0.
- R7: Operation code 2'b11 (toggle) returns the operand with the selected bit inverted.
- R8: With kind = 0 (32-bit register), the selected bit is bit_num modulo 32, i.e. bit_num[4:0].
- R9: With kind = 1 (memory byte), the selected bit is bit_num modulo 8 within operand[7:0], and result[31:8] equals operand[31:8].
- R10: All flags_out bits other than bit 2 equal the corresponding flags_in bits of the same request.
- R11: wr_en is 1 in a result cycle exactly when that result comes from a set, clear or toggle request.
- R12: result differs from the operand in at most one bit position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | 00 test, 01 set, 10 clear, 11 toggle |
| kind | input | 1 | 0 = 32-bit register operand, 1 = 8-bit byte operand |
| operand | input | 32 | Operand value; byte operands in bits 7:0 |
| bit_num | input | 6 | Bit number before modulo reduction |
| flags_in | input | 5 | Current condition flags; bit 2 is the zero flag |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Operand after modification |
| flags_out | output | 5 | Flags with the zero flag updated |
| wr_en | output | 1 | Result must be written back |

## Verification
The hardest cases to reach are bit numbers at and beyond the operand width, where modulo wrap-around for a byte operand must leave bits above 7 untouched while the same number on a register selects a high bit. The stimulus sweeps every bit number from 0 to 63 against both operand kinds and all four operations, over all-zero, all-one and mixed operands, so each wrapped index is hit with the bit both clear and set. Requests are streamed back to back so that every result is compared in the cycle after its request with no idle gap hiding a stale value.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_FLIP = 2'b11
  } bitop_e;

  typedef enum logic {
    KIND_WORD = 1'b0,
    KIND_BYTE = 1'b1
  } opnd_kind_e;

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/bit_sel_decode.sv
module bit_sel_decode
  import bitop_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 6
) (
  input  logic                kind,
  input  logic [BITNUM_W-1:0] bit_num,
  output logic [WORD_W-1:0]   sel_mask
);

  localparam int WIDX = $clog2(WORD_W);
  localparam int BIDX = $clog2(BYTE_W);

  logic [WIDX-1:0] word_idx;
  logic [BIDX-1:0] byte_idx;

  // modulo reduction is a plain truncation for power-of-two widths
  assign word_idx = bit_num[WIDX-1:0];
  assign byte_idx = bit_num[BIDX-1:0];

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    if (i < BYTE_W) begin : g_low
      always_comb begin
        if (opnd_kind_e'(kind) == KIND_BYTE) begin
          sel_mask[i] = (byte_idx == BIDX'(i));
        end else begin
          sel_mask[i] = (word_idx == WIDX'(i));
        end
      end
    end else begin : g_high
      always_comb begin
        if (opnd_kind_e'(kind) == KIND_BYTE) begin
          sel_mask[i] = 1'b0;
        end else begin
          sel_mask[i] = (word_idx == WIDX'(i));
        end
      end
    end
  end

endmodule

// File: rtl/bit_update_core.sv
module bit_update_core
  import bitop_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 5,
  parameter int ZPOS   = 2
) (
  input  logic [1:0]        op,
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] sel_mask,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [WORD_W-1:0] new_value,
  output logic [FLAG_W-1:0] new_flags,
  output logic              needs_wr
);

  logic orig_bit;

  assign orig_bit = |(operand & sel_mask);

  always_comb begin
    new_flags       = flags_in;
    new_flags[ZPOS] = ~orig_bit;
  end

  always_comb begin
    new_value = operand;
    needs_wr  = 1'b1;
    unique case (bitop_e'(op))
      OP_TEST: needs_wr  = 1'b0;
      OP_SET:  new_value = operand | sel_mask;
      OP_CLR:  new_value = operand & ~sel_mask;
      OP_FLIP: new_value = operand ^ sel_mask;
      default: needs_wr  = 1'b0;
    endcase
  end

endmodule

// File: rtl/bit_tam_unit.sv
module bit_tam_unit
  import bitop_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 6,
  parameter int FLAG_W   = 5,
  parameter int ZPOS     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op,
  input  logic                kind,
  input  logic [WORD_W-1:0]   operand,
  input  logic [BITNUM_W-1:0] bit_num,
  input  logic [FLAG_W-1:0]   flags_in,
  output logic                out_valid,
  output logic [WORD_W-1:0]   result,
  output logic [FLAG_W-1:0]   flags_out,
  output logic                wr_en
);

  localparam logic [FLAG_W-1:0] ZMASK = FLAG_W'(1) << ZPOS;

  logic              rst_i_n;
  logic [WORD_W-1:0] sel_mask;
  logic [WORD_W-1:0] new_value;
  logic [FLAG_W-1:0] new_flags;
  logic              needs_wr;

  logic              valid_d, wr_d;
  logic [WORD_W-1:0] result_d;
  logic [FLAG_W-1:0] flags_d;

  rst_release_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i_n)
  );

  bit_sel_decode #(
    .WORD_W   (WORD_W),
    .BYTE_W   (BYTE_W),
    .BITNUM_W (BITNUM_W)
  ) u_decode (
    .kind     (kind),
    .bit_num  (bit_num),
    .sel_mask (sel_mask)
  );

  bit_update_core #(
    .WORD_W (WORD_W),
    .FLAG_W (FLAG_W),
    .ZPOS   (ZPOS)
  ) u_core (
    .op        (op),
    .operand   (operand),
    .sel_mask  (sel_mask),
    .flags_in  (flags_in),
    .new_value (new_value),
    .new_flags (new_flags),
    .needs_wr  (needs_wr)
  );

  // next-state
  always_comb begin
    valid_d  = in_valid;
    wr_d     = in_valid & needs_wr;
    result_d = new_value;
    flags_d  = new_flags;
  end

  // control registers, updated every cycle
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= valid_d;
      wr_en     <= wr_d;
    end
  end

  // data registers, enabled by a request
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      result    <= '0;
      flags_out <= '0;
    end else if (in_valid) begin
      result    <= result_d;
      flags_out <= flags_d;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid |=> out_valid);

  // R2
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !in_valid |=> !out_valid);

  // R11
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |-> out_valid);

  // R4
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && op == OP_TEST) |=> (result == $past(operand) && !wr_en));

  // R3
  set_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && op == OP_SET) |=> (flags_out[ZPOS] == (result != $past(operand))));

  // R7
  flip_change_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && op == OP_FLIP) |=> ($countones(result ^ $past(operand)) == 1));

  // R10
  flag_pass_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid |=> ((flags_out & ~ZMASK) == ($past(flags_in) & ~ZMASK)));

  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && kind == KIND_BYTE) |=>
      (result[WORD_W-1:BYTE_W] == $past(operand[WORD_W-1:BYTE_W])));

  // R12
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid |=> ($countones(result ^ $past(operand)) <= 1));

endmodule

// File: tb/test_bit_tam_unit.sv
module test_bit_tam_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic        kind;
  logic [31:0] operand;
  logic [5:0]  bit_num;
  logic [4:0]  flags_in;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  flags_out;
  logic        wr_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bit_tam_unit i_bit_tam_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .kind      (kind),
    .operand   (operand),
    .bit_num   (bit_num),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] exp_res;
    logic [4:0]  exp_flg;
    int          idx;
    logic        orig;
    logic [1:0]  p_op;
    logic        p_kind;
    logic [31:0] p_opnd;
    logic [5:0]  p_bn;
    logic [4:0]  p_flg;
    logic        have_prev;

    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5C3_5A3C;
    pats[3] = 32'h1234_8E71;

    rst_n = 1'b0; in_valid = 1'b0; op = 2'b00; kind = 1'b0;
    operand = '0; bit_num = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1 wr_en in reset", {31'b0, wr_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid after release", {31'b0, out_valid}, 32'd0);
    check("R1 wr_en after release", {31'b0, wr_en}, 32'd0);

    have_prev = 1'b0;
    p_op = '0; p_kind = 1'b0; p_opnd = '0; p_bn = '0; p_flg = '0;
    for (int pi = 0; pi < 4; pi++) begin
      for (int k = 0; k < 2; k++) begin
        for (int o = 0; o < 4; o++) begin
          for (int b = 0; b < 64; b++) begin
            in_valid = 1'b1;
            op       = 2'(o);
            kind     = 1'(k);
            operand  = pats[pi] ^ {26'b0, 6'(b)} ^ 32'(o << 16);
            bit_num  = 6'(b);
            flags_in = 5'(b * 7 + o);
            @(negedge clk);
            // result of the request just presented, one register later
            idx  = (kind == 1'b1) ? (int'(bit_num) % 8) : (int'(bit_num) % 32);
            orig = operand[idx];
            exp_res = operand;
            case (op)
              2'b01: exp_res[idx] = 1'b1;
              2'b10: exp_res[idx] = 1'b0;
              2'b11: exp_res[idx] = ~orig;
              default: ;
            endcase
            exp_flg = flags_in;
            exp_flg[2] = ~orig;
            check(kind ? {op_tag(op), " R9 result"} : {op_tag(op), " R8 result"},
                  result, exp_res);
            check("R3 R10 flags", {27'b0, flags_out}, {27'b0, exp_flg});
            check("R11 wr_en", {31'b0, wr_en}, {31'b0, (op != 2'b00)});
            check("R2 out_valid", {31'b0, out_valid}, 32'd1);
            if (kind == 1'b1)
              check("R9 upper bits kept", {8'b0, result[31:8]}, {8'b0, operand[31:8]});
            check("R12 single bit", 32'($countones(result ^ operand)),
                  (op == 2'b11) ? 32'd1 : ((exp_res != operand) ? 32'd1 : 32'd0));
            p_op = op; p_kind = kind; p_opnd = operand; p_bn = bit_num; p_flg = flags_in;
            have_prev = 1'b1;
          end
        end
      end
    end

    // idle cycle: no result, no write
    in_valid = 1'b0;
    op = 2'b01;
    @(negedge clk);
    check("R2 out_valid idle", {31'b0, out_valid}, 32'd0);
    check("R11 wr_en idle", {31'b0, wr_en}, 32'd0);

    // explicit wrap corners
    in_valid = 1'b1; op = 2'b01; kind = 1'b1; operand = 32'h0000_0000; bit_num = 6'd63;
    flags_in = 5'b11111;
    @(negedge clk);
    check("R9 byte index 63 sets bit 7", result, 32'h0000_0080);
    check("R3 zero flag set from clear bit", {31'b0, flags_out[2]}, 32'd1);
    kind = 1'b0;
    @(negedge clk);
    check("R8 word index 63 sets bit 31", result, 32'h8000_0000);
    op = 2'b10; operand = 32'hFFFF_FFFF; bit_num = 6'd32;
    @(negedge clk);
    check("R8 word index 32 clears bit 0", result, 32'hFFFF_FFFE);
    check("R3 zero flag clear from set bit", {31'b0, flags_out[2]}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule